// File: doc/BRIEF.md
# Overhead Value Integrator with Instability Flag

This block filters a field of overhead (one bit, a group of bits or a byte) that a framer recovers once per frame. On each cycle where the occurrence strobe is high, the block takes one W-bit received value. The stored value is replaced only when a different value has been seen on several consecutive occurrences, so a single corrupted frame cannot disturb the register that software or downstream logic reads.

Alongside the persistence filter, the block flags a field whose value will not settle. An occurrence is counted as a miss when it matches neither the stored value nor the value received just before it. A long unbroken run of misses raises the unstable flag. The flag drops again once any one value has repeated for the persistence length. A one-cycle pulse marks each update of the stored value.

Top module: `ovh_integrator`

## Requirements
- R1: The stored value `held_value` takes a new value V on the clock edge of the fifth consecutive occurrence carrying V, where V differs from the stored value. It is unchanged before that edge.
- R2: An occurrence equal to the stored value never alters it, and it breaks any run of another value in progress.
- R3: An occurrence that differs from the previous received value restarts the run at one, so a new value needs five further identical occurrences.
- R4: `unstable` goes high on the edge of the eighth consecutive occurrence that matches neither the stored value nor the previous received value.
- R5: `unstable` goes low on the edge of the fifth consecutive identical occurrence, whether or not that value equals the stored value.
- R6: The miss count saturates at eight. Further misses keep `unstable` high and never wrap it low.
- R7: Cycles with `occ_valid` low change no state and no output, whatever `occ_value` carries.
- R8: `change_pulse` is high for exactly the one cycle that follows each update of `held_value`, and is low otherwise.
- R9: The bit order is preserved. `occ_value[W-1]` holds the first received bit of the field and lands in `held_value[W-1]`, with no reversal.
- R10: While reset is asserted, and directly after it, `held_value`, the previous value, both counts, `unstable` and `change_pulse` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| occ_valid | input | 1 | High for one cycle per received occurrence of the field |
| occ_value | input | W | Received field value, first received bit at index W-1 |
| held_value | output | W | Integrated (stored) field value |
| change_pulse | output | 1 | One-cycle pulse after `held_value` changes |
| unstable | output | 1 | Received field is not settling |

## Verification
The assertions assume that `occ_value` is a known value on every cycle where `occ_valid` is high. They place no constraint on how often occurrences arrive, because the block counts occurrences and not cycles. The stimulus always drives defined values and inserts idle cycles carrying unrelated values, so that it exercises the hold behaviour without violating those assumptions. With a two-bit field, every sequence of six occurrences is applied after a reset. A long pseudo-random stream then produces the eight-miss runs that short sequences cannot reach.

// File: rtl/ovh_integrator.sv
module ovh_integrator #(
  parameter int W            = 8,
  parameter int PERSIST      = 5,
  parameter int UNSTABLE_RUN = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         occ_valid,
  input  logic [W-1:0] occ_value,
  output logic [W-1:0] held_value,
  output logic         change_pulse,
  output logic         unstable
);
  localparam int RW = $clog2(PERSIST + 1);
  localparam int UW = $clog2(UNSTABLE_RUN + 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(PERSIST);
  localparam logic [UW-1:0] MIS_FULL = UW'(UNSTABLE_RUN);

  logic [W-1:0]  held_q, prev_q;
  logic [RW-1:0] run_q, run_nx;
  logic [UW-1:0] mis_q, mis_nx;
  logic          uns_q, pulse_q;

  wire same_prev = (occ_value == prev_q);
  wire same_held = (occ_value == held_q);
  wire miss      = !same_held && !same_prev;

  assign run_nx = !same_prev ? RW'(1) :
                  (run_q == RUN_FULL) ? run_q : run_q + RW'(1);
  assign mis_nx = !miss ? '0 :
                  (mis_q == MIS_FULL) ? mis_q : mis_q + UW'(1);

  wire adopt = occ_valid && !same_held && (run_nx == RUN_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '0;
      prev_q  <= '0;
      run_q   <= '0;
      mis_q   <= '0;
      uns_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= adopt;
      if (occ_valid) begin
        prev_q <= occ_value;
        run_q  <= run_nx;
        mis_q  <= mis_nx;
        if (adopt) held_q <= occ_value;
        if (mis_nx == MIS_FULL)      uns_q <= 1'b1;
        else if (run_nx == RUN_FULL) uns_q <= 1'b0;
      end
    end
  end

  assign held_value   = held_q;
  assign change_pulse = pulse_q;
  assign unstable     = uns_q;

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !occ_valid |=> ($stable(held_value) && $stable(unstable) && !change_pulse));

  // R8
  change_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_value != $past(held_value)) |-> change_pulse);

  // R1
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    change_pulse |-> ($past(occ_valid) && held_value == $past(occ_value)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mis_q <= MIS_FULL);

  // R4
  unstable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unstable) |-> $past(occ_valid && occ_value != prev_q && occ_value != held_q));

  // R5
  unstable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unstable) |-> $past(occ_valid && occ_value == prev_q));
endmodule

// File: tb/ovh_integrator_bench.sv
module ovh_integrator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 2;

  logic clk = 1'b0, rst_n = 1'b0, occ_valid = 1'b0;
  logic [W-1:0] occ_value = '0;
  logic [W-1:0] held_value;
  logic change_pulse, unstable;

  int checks = 0, fails = 0;
  int m_held, m_prev, m_run, m_mis;
  bit m_uns, m_pulse;
  int lcg = 12345;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovh_integrator #(.W(W), .PERSIST(5), .UNSTABLE_RUN(8)) u_ovh_integrator (
    .clk(clk), .rst_n(rst_n), .occ_valid(occ_valid), .occ_value(occ_value),
    .held_value(held_value), .change_pulse(change_pulse), .unstable(unstable));

  task automatic compare(input string tag);
    checks++;
    if (held_value !== W'(m_held) || change_pulse !== m_pulse || unstable !== m_uns) begin
      fails++;
      $display("FAIL %s: held=%0d pulse=%0b unstable=%0b expected held=%0d pulse=%0b unstable=%0b",
               tag, held_value, change_pulse, unstable, m_held, m_pulse, m_uns);
    end
  endtask

  task automatic do_reset(input bit check);
    rst_n = 1'b0; occ_valid = 1'b0; occ_value = '0;
    m_held = 0; m_prev = 0; m_run = 0; m_mis = 0; m_uns = 0; m_pulse = 0;
    @(negedge clk);
    if (check) compare("R10 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    if (check) compare("R10 after reset");
  endtask

  task automatic step(input bit vld, input int v, input string tag);
    bit same_prev, miss;
    occ_valid = vld; occ_value = W'(v);
    m_pulse = 0;
    if (vld) begin
      same_prev = (v == m_prev);
      m_run = same_prev ? ((m_run < 5) ? m_run + 1 : 5) : 1;
      miss  = (v != m_held) && !same_prev;
      m_mis = miss ? ((m_mis < 8) ? m_mis + 1 : 8) : 0;
      if (v != m_held && m_run == 5) begin m_held = v; m_pulse = 1; end
      if (m_mis == 8) m_uns = 1;
      else if (m_run == 5) m_uns = 0;
      m_prev = v;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1);
    // R9: asymmetric value kept in the same bit order
    for (int i = 0; i < 5; i++) step(1, 2, "R9");
    // R2: stored value interrupts a run of another value
    for (int i = 0; i < 4; i++) step(1, 1, "R2");
    step(1, 2, "R2");
    for (int i = 0; i < 4; i++) step(1, 1, "R2");
    // R3: change restarts the run
    step(1, 3, "R3");
    for (int i = 0; i < 5; i++) step(1, 1, "R3");
    // R7: idle cycles carry unrelated values
    for (int i = 0; i < 4; i++) step(0, i, "R7");
    step(1, 3, "R7");
    for (int i = 0; i < 3; i++) step(0, 3 - i, "R7");
    // R4 then R6: cycling values never match
    do_reset(0);
    for (int i = 0; i < 8; i++) step(1, 1 + (i % 3), "R4");
    for (int i = 0; i < 12; i++) step(1, 1 + ((i + 2) % 3), "R6");
    // R5: five identical occurrences clear the flag
    for (int i = 0; i < 5; i++) step(1, 2, "R5");
    for (int i = 0; i < 9; i++) step(1, 3 - (i % 3), "R4");
    for (int i = 0; i < 5; i++) step(1, 2, "R5 stored value");
    // R1, R8: every six-occurrence sequence, with an idle cycle for odd codes
    for (int s = 0; s < 4096; s++) begin
      do_reset(0);
      for (int k = 0; k < 6; k++) begin
        if (k == 3 && s[0]) step(0, s[1:0], "R7");
        step(1, (s >> (2 * k)) & 3, "R1");
      end
    end
    // R4, R5, R6, R8: long pseudo-random stream
    do_reset(0);
    for (int i = 0; i < 20000; i++) begin
      lcg = lcg * 1103515245 + 12345;
      step(((lcg >>> 20) & 7) != 0, (lcg >>> 16) & 3, "R8");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule